// File: doc/BRIEF.md
# Modulated Phase Shift Counter

This block times the lag between the rising edge of a transmitted modulation reference and the rising edge of the envelope recovered on each of two receive channels, sine and cosine. A single period counter is restarted by every reference edge. The counter advances once per clock, and the clock runs at four times the RF carrier. Each channel captures the counter value when its own receive edge arrives. The modulation period spans about a thousand carrier periods, so a full-period lag of roughly 4000 counts fits in a 12-bit unsigned result. Counting is independent of how the earlier results are consumed, so a new measurement can build up while the previous one is still being processed.

All three edge inputs are brought into the clock domain through two-flop synchronizers. Only their rising transitions take part in the measurement. When both channels have finalized a value, a ready flag is raised and a one-cycle interrupt pulse wakes a sleeping processor. The processor's read strobe clears the flag. A channel that sees no receive edge within a period reports a saturated value and a missing-edge bit.

Top module: `phase_lag_timer`

## Requirements
- R1: After reset, both results and both missing-edge bits read 0, and `ready_o` and `irq_o` are low.
- R2: A channel's result equals the number of clock cycles between the sampled rising edge of `mod_ref_i` and the sampled rising edge of that channel's receive input. The new value appears on the output three clock edges after the receive rise is first sampled.
- R3: The sine and cosine channels measure independently, each into its own result register, whichever of them arrives first.
- R4: The period counter saturates at 4095. A receive edge arriving 4095 or more cycles after the reference edge yields 4095 with the missing-edge bit clear.
- R5: If a channel sees no receive edge between two reference edges, the second reference edge sets its result to 4095 and its missing-edge bit to 1. The next successful capture clears the bit.
- R6: Only the first receive rising edge after a reference edge is captured. Later rising edges in the same period, and all falling edges, leave the result unchanged.
- R7: `ready_o` rises once both channels have finalized a value (a capture or a missed edge). `irq_o` is high for exactly one cycle, in the first cycle that `ready_o` is high.
- R8: A one-cycle `rd_i` pulse clears `ready_o` on the next cycle and leaves both results unchanged.
- R9: While `en_i` is low, all edges are ignored and every output holds its value. After `en_i` returns high, the first reference edge re-arms both channels without reporting a missed edge.
- R10: When a reference edge and a receive edge are sampled in the same cycle, the reference edge takes priority and that receive edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, four times the RF carrier |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Measurement enable |
| mod_ref_i | input | 1 | Transmitted modulation reference (asynchronous) |
| rx_sin_i | input | 1 | Sine-channel receive envelope edge (asynchronous) |
| rx_cos_i | input | 1 | Cosine-channel receive envelope edge (asynchronous) |
| rd_i | input | 1 | One-cycle strobe: processor has read a result |
| sin_phase_o | output | 12 | Sine-channel lag count |
| cos_phase_o | output | 12 | Cosine-channel lag count |
| sin_miss_o | output | 1 | Sine channel saw no edge in the last period |
| cos_miss_o | output | 1 | Cosine channel saw no edge in the last period |
| ready_o | output | 1 | Both channels hold a new value |
| irq_o | output | 1 | One-cycle data-ready interrupt |

## Verification
The assertions take for granted that `en_i` and `rd_i` are synchronous to `clk`, that `rd_i` is a single-cycle strobe, and that each receive and reference input stays at one level for at least one full clock so that the synchronizer sees a clean transition. The stimulus holds every receive pulse high for four cycles and holds the reference high for half of each period. It changes `en_i` and `rd_i` only on falling clock edges, and issues reads only between periods, so that no capture coincides with a read.

// File: rtl/phl_pkg.sv
package phl_pkg;

    localparam int CNT_W       = 12;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_CH      = 2;
    localparam int CH_SIN      = 0;
    localparam int CH_COS      = 1;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        cnt_t value;
        logic miss;
    } phase_res_t;

    function automatic cnt_t sat_inc(input cnt_t c);
        return (c == CNT_MAX) ? c : c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/phl_edge_sync.sv
module phl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign rise_o = sh_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/phl_period_ctr.sv
module phl_period_ctr
    import phl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ref_rise,
    output cnt_t cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_o <= CNT_MAX;
        end else if (ref_rise) begin
            cnt_o <= cnt_t'(1);
        end else begin
            cnt_o <= sat_inc(cnt_o);
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && !ref_rise) |=> (cnt_o >= $past(cnt_o))); // R4

endmodule

// File: rtl/phl_channel.sv
module phl_channel
    import phl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ref_rise,
    input  logic       rx_rise,
    input  cnt_t       cnt,
    output phase_res_t res_o,
    output logic       fin_o
);
    logic armed_q;

    assign fin_o = en & armed_q & (ref_rise | rx_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            res_o   <= '0;
        end else if (!en) begin
            armed_q <= 1'b0;
        end else if (ref_rise) begin
            if (armed_q) begin
                res_o.value <= CNT_MAX;
                res_o.miss  <= 1'b1;
            end
            armed_q <= 1'b1;
        end else if (rx_rise && armed_q) begin
            res_o.value <= cnt;
            res_o.miss  <= 1'b0;
            armed_q     <= 1'b0;
        end
    end

    AST_MISS_SATURATED: assert property (@(posedge clk) disable iff (rst)
        res_o.miss |-> (res_o.value == CNT_MAX)); // R5

    AST_LATE_RX_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rx_rise && !armed_q) |=> $stable(res_o)); // R6

    AST_REF_WINS: assert property (@(posedge clk) disable iff (rst)
        (en && ref_rise && rx_rise && armed_q) |=> res_o.miss); // R10

endmodule

// File: rtl/phl_ready.sv
module phl_ready
    import phl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] fin_i,
    input  logic              rd_i,
    output logic              ready_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] done_q;
    logic [NUM_CH-1:0] done_nx;

    assign done_nx = (done_q & ~{NUM_CH{rd_i}}) | fin_i;
    assign ready_o = &done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
            irq_o  <= 1'b0;
        end else begin
            done_q <= done_nx;
            irq_o  <= (&done_nx) & ~(&done_q);
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o); // R7

    AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ready_o); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (fin_i == '0)) |=> !ready_o); // R8

endmodule

// File: rtl/phase_lag_timer.sv
module phase_lag_timer
    import phl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             mod_ref_i,
    input  logic             rx_sin_i,
    input  logic             rx_cos_i,
    input  logic             rd_i,
    output logic [CNT_W-1:0] sin_phase_o,
    output logic [CNT_W-1:0] cos_phase_o,
    output logic             sin_miss_o,
    output logic             cos_miss_o,
    output logic             ready_o,
    output logic             irq_o
);
    localparam int IDX_REF = 0;
    localparam int N_IN    = NUM_CH + 1;

    logic [N_IN-1:0]   raw;
    logic [N_IN-1:0]   rise;
    cnt_t              cnt;
    phase_res_t        res [NUM_CH];
    logic [NUM_CH-1:0] fin;

    assign raw = {rx_cos_i, rx_sin_i, mod_ref_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        phl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .din    (raw[g]),
            .rise_o (rise[g])
        );
    end

    phl_period_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .en       (en_i),
        .ref_rise (rise[IDX_REF]),
        .cnt_o    (cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        phl_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .en       (en_i),
            .ref_rise (rise[IDX_REF]),
            .rx_rise  (rise[c+1]),
            .cnt      (cnt),
            .res_o    (res[c]),
            .fin_o    (fin[c])
        );
    end

    phl_ready u_rdy (
        .clk     (clk),
        .rst     (rst),
        .fin_i   (fin),
        .rd_i    (rd_i),
        .ready_o (ready_o),
        .irq_o   (irq_o)
    );

    assign sin_phase_o = res[CH_SIN].value;
    assign cos_phase_o = res[CH_COS].value;
    assign sin_miss_o  = res[CH_SIN].miss;
    assign cos_miss_o  = res[CH_COS].miss;

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(sin_phase_o) && $stable(cos_phase_o)
                   && $stable(sin_miss_o) && $stable(cos_miss_o))); // R9

endmodule

// File: tb/tb_phase_lag_timer.sv
module tb_phase_lag_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b1;
    logic        mod_ref_i = 1'b0;
    logic        rx_sin_i = 1'b0;
    logic        rx_cos_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [11:0] sin_phase_o, cos_phase_o;
    logic        sin_miss_o, cos_miss_o, ready_o, irq_o;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    bit running = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    phase_lag_timer dut (
        .clk(clk), .rst(rst), .en_i(en_i), .mod_ref_i(mod_ref_i),
        .rx_sin_i(rx_sin_i), .rx_cos_i(rx_cos_i), .rd_i(rd_i),
        .sin_phase_o(sin_phase_o), .cos_phase_o(cos_phase_o),
        .sin_miss_o(sin_miss_o), .cos_miss_o(cos_miss_o),
        .ready_o(ready_o), .irq_o(irq_o)
    );

    // Behavioural reference: sampled-input history, elapsed count, per-channel state
    bit q_ref[$], q_sin[$], q_cos[$];
    int m_cnt;
    bit m_arm[2];
    int m_val[2];
    bit m_miss[2];
    bit m_done[2];
    bit m_irq;

    task automatic model_reset();
        q_ref = '{0, 0, 0, 0};
        q_sin = '{0, 0, 0, 0};
        q_cos = '{0, 0, 0, 0};
        m_cnt = 4095;
        m_irq = 0;
        for (int c = 0; c < 2; c++) begin
            m_arm[c] = 0; m_val[c] = 0; m_miss[c] = 0; m_done[c] = 0;
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit re;
            bit ed[2];
            bit fin[2];
            bit was_ready;
            re    = q_ref[1] && !q_ref[2];
            ed[0] = q_sin[1] && !q_sin[2];
            ed[1] = q_cos[1] && !q_cos[2];
            for (int c = 0; c < 2; c++) begin
                fin[c] = 0;
                if (!en_i) begin
                    m_arm[c] = 0;
                end else if (re) begin
                    if (m_arm[c]) begin
                        m_val[c] = 4095; m_miss[c] = 1; fin[c] = 1;
                    end
                    m_arm[c] = 1;
                end else if (ed[c] && m_arm[c]) begin
                    m_val[c] = m_cnt; m_miss[c] = 0; m_arm[c] = 0; fin[c] = 1;
                end
            end
            if (!en_i) m_cnt = 4095;
            else if (re) m_cnt = 1;
            else if (m_cnt < 4095) m_cnt = m_cnt + 1;
            was_ready = m_done[0] && m_done[1];
            for (int c = 0; c < 2; c++) m_done[c] = (m_done[c] && !rd_i) || fin[c];
            m_irq = m_done[0] && m_done[1] && !was_ready;
            q_ref.push_front(mod_ref_i); void'(q_ref.pop_back());
            q_sin.push_front(rx_sin_i);  void'(q_sin.pop_back());
            q_cos.push_front(rx_cos_i);  void'(q_cos.pop_back());
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (irq_o) irq_seen++;
        if (running && !rst) begin
            chk("R2 sin value vs model", int'(sin_phase_o), m_val[0]);
            chk("R3 cos value vs model", int'(cos_phase_o), m_val[1]);
            chk("R5 sin miss vs model", int'(sin_miss_o), int'(m_miss[0]));
            chk("R5 cos miss vs model", int'(cos_miss_o), int'(m_miss[1]));
            chk("R7 ready vs model", int'(ready_o), int'(m_done[0] && m_done[1]));
            chk("R7 irq vs model", int'(irq_o), int'(m_irq));
        end
    end

    // One modulation period: reference high for the first half; receive pulses 4 cycles wide
    task automatic period(input int len, input int ds, input int dc, input int ds2);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mod_ref_i = (i < len / 2);
            rx_sin_i  = (ds >= 0 && i >= ds && i < ds + 4) ||
                        (ds2 >= 0 && i >= ds2 && i < ds2 + 4);
            rx_cos_i  = (dc >= 0 && i >= dc && i < dc + 4);
        end
        @(negedge clk);
        mod_ref_i = 0; rx_sin_i = 0; rx_cos_i = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_pulse();
        @(negedge clk); rd_i = 1;
        @(negedge clk); rd_i = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired (all requirements): actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int keep_s, keep_c, keep_r;
        repeat (3) @(negedge clk);
        chk("R1 reset sin", int'(sin_phase_o), 0);
        chk("R1 reset cos", int'(cos_phase_o), 0);
        chk("R1 reset miss", int'(sin_miss_o | cos_miss_o), 0);
        chk("R1 reset ready/irq", int'(ready_o | irq_o), 0);
        rst = 0;
        running = 1;
        repeat (3) @(negedge clk);

        irq_seen = 0;
        period(100, 10, 20, -1);
        chk("R2 sin lag 10", int'(sin_phase_o), 10);
        chk("R3 cos lag 20", int'(cos_phase_o), 20);
        chk("R7 ready after both", int'(ready_o), 1);
        chk("R7 single irq", irq_seen, 1);

        read_pulse();
        chk("R8 ready cleared", int'(ready_o), 0);
        chk("R8 sin kept", int'(sin_phase_o), 10);

        period(100, 37, 5, -1);
        chk("R3 sin later than cos", int'(sin_phase_o), 37);
        chk("R3 cos early", int'(cos_phase_o), 5);

        period(200, 30, 50, 90);
        chk("R6 second rx edge ignored", int'(sin_phase_o), 30);

        period(4200, 4150, 100, -1);
        chk("R4 saturated value", int'(sin_phase_o), 4095);
        chk("R4 saturated no miss", int'(sin_miss_o), 0);

        period(100, -1, 40, -1);
        period(60, -1, -1, -1);
        chk("R5 missing sin value", int'(sin_phase_o), 4095);
        chk("R5 missing sin flag", int'(sin_miss_o), 1);
        chk("R5 cos unaffected", int'(cos_phase_o), 40);
        period(100, 12, 14, -1);
        chk("R5 miss cleared by capture", int'(sin_miss_o), 0);
        chk("R5 new value", int'(sin_phase_o), 12);

        period(100, 25, 20, -1);
        period(100, 0, 20, -1);
        chk("R10 coincident rx ignored", int'(sin_phase_o), 25);
        period(60, -1, -1, -1);
        chk("R10 channel left armed", int'(sin_miss_o), 1);

        period(100, 8, 9, -1);
        keep_s = sin_phase_o; keep_c = cos_phase_o; keep_r = ready_o;
        @(negedge clk); en_i = 0;
        irq_seen = 0;
        period(100, 10, 20, -1);
        chk("R9 sin held", int'(sin_phase_o), keep_s);
        chk("R9 cos held", int'(cos_phase_o), keep_c);
        chk("R9 ready held", int'(ready_o), keep_r);
        chk("R9 no irq", irq_seen, 0);
        @(negedge clk); en_i = 1;
        period(100, 15, 25, -1);
        chk("R9 resumed sin", int'(sin_phase_o), 15);
        chk("R9 no false miss", int'(sin_miss_o | cos_miss_o), 0);

        running = 0;
        finished = 1;
        summary();
        $finish;
    end

endmodule